// File: doc/BRIEF.md
# Step Attenuator Control Latch

This block is the digital control front end of a binary-weighted step attenuator with seven stages. A control word reaches the seven stage-enable outputs through one of two paths. The first is a three-wire serial path made of a data line, a shift clock and a latch enable. The second is a parallel bus of seven lines. A mode input picks the active path. The latch-enable input decides when the active word is copied into the output register that drives the stage selects. A second output gives the total attenuation in quarter-dB units. Every input is synchronous to the system clock `clk`. The serial shift clock is treated as a data input, and its rising edges are found by comparing it with its value one clock earlier.

The sequencing is done by a control state machine with five states:
- `ST_BOOT`: the state right after reset, before any path has been seen.
- `ST_SER_SHIFT`: serial mode with latch enable low. Shift-clock edges are accepted here.
- `ST_SER_HOLD`: serial mode with latch enable high. The shift clock is masked.
- `ST_PAR_OPEN`: parallel mode with latch enable high. The output register follows the bus.
- `ST_PAR_HOLD`: parallel mode with latch enable low. The output register holds.

Every clock, the next state is taken directly from the mode and latch-enable inputs. The actions belong to the transitions:
- `ST_SER_SHIFT` or `ST_PAR_HOLD` to `ST_SER_HOLD` is a serial transfer, because latch enable rose in serial mode.
- Any transition into `ST_PAR_OPEN` is a parallel load.
- Any transition into `ST_SER_SHIFT` that coincides with a shift-clock rising edge shifts in one bit.
- `ST_BOOT` to `ST_SER_HOLD`, and `ST_PAR_OPEN` to `ST_SER_HOLD`, change nothing, because latch enable did not rise.
- The remaining transitions keep the output register as it is.

Top module: `step_atten_ctrl`

## Requirements
- R1: An active-low asynchronous reset sets all seven stage selects to 1, so `atten_qdb` reads 127, and clears the shift register to zero. A serial transfer made right after reset, with no shift-clock edges, therefore yields code 0.
- R2: `ser_mode` = 1 selects the serial path and `ser_mode` = 0 selects the parallel path. The inactive path cannot change the output register, and serial data cannot be shifted while the parallel path is selected.
- R3: In serial mode, each rising edge of `ser_clk` seen while `latch_en` is low shifts `ser_din` in. The bits enter MSB first, so after seven edges the first bit sent sits at bit 6.
- R4: While `latch_en` is high, edges on `ser_clk` are ignored and the shift register keeps its contents.
- R5: In serial mode, a rising edge of `latch_en` copies the shift register into the stage selects. The result is visible one `clk` after the edge is sampled. Shifting alone never changes the stage selects.
- R6: In parallel mode with `latch_en` high, the stage selects follow `par_word`, one `clk` later.
- R7: In parallel mode with `latch_en` low, changes on `par_word` have no effect. A high pulse on `latch_en` transfers the bus value, and the value on the bus when `latch_en` falls is the one that is held.
- R8: Bit i of `stage_sel` enables a stage of 2^i quarter-dB: bit 6 is the 16 dB stage and bit 0 is the 0.25 dB stage. `atten_qdb` is the sum of the enabled stages, which equals the code as an unsigned number, with a maximum of 127 (31.75 dB).
- R9: A change of `ser_mode` while `latch_en` is low leaves the stage selects unchanged.
- R10: If more than seven bits are shifted before a transfer, only the last seven bits sent are kept, in their order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| ser_mode | input | 1 | 1 = serial path, 0 = parallel path |
| ser_clk | input | 1 | Serial shift clock; its rising edges are detected against `clk` |
| ser_din | input | 1 | Serial data bit, MSB first |
| latch_en | input | 1 | Latch enable for the output register |
| par_word | input | 7 | Parallel control word |
| stage_sel | output | 7 | Stage-enable bits, bit i enables 2^i quarter-dB |
| atten_qdb | output | 7 | Total attenuation in 0.25 dB units |

## Verification
The bench builds the block with its default width of seven stages. At that width, every one of the 128 codes can be sent over the serial path and every one can be applied over the direct parallel path. This exercises each stage bit and the whole quarter-dB sum in both directions. The small width also makes it cheap to cover the corners:
- reset at power-up and again in the middle of a run;
- an over-length serial stream;
- shift-clock edges while the latch is high;
- a mode switch while the latch is low;
- a latched parallel walk in which the bus changes on both sides of each latch pulse.

// File: rtl/step_atten_pkg.sv
package step_atten_pkg;

    parameter int STAGES = 7;

    typedef enum logic [2:0] {
        ST_BOOT      = 3'd0,
        ST_SER_SHIFT = 3'd1,
        ST_SER_HOLD  = 3'd2,
        ST_PAR_OPEN  = 3'd3,
        ST_PAR_HOLD  = 3'd4
    } ctrl_state_e;

endpackage

// File: rtl/atten_ctrl_fsm.sv
module atten_ctrl_fsm
    import step_atten_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ser_mode,
    input  logic        latch_en,
    input  logic        ser_clk,
    output logic        shift_en,
    output logic        load_shift,
    output logic        load_par,
    output ctrl_state_e state
);

    ctrl_state_e cur_state;
    ctrl_state_e nxt_state;
    logic        sclk_q;
    logic        sclk_rise;

    // Edge detector for the shift clock. The register resets to 1 so that a
    // shift clock already high when reset is released is not taken as an edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b1;
        end else begin
            sclk_q <= ser_clk;
        end
    end

    assign sclk_rise = ser_clk && !sclk_q;

    // Next state depends only on the mode and latch-enable inputs.
    always_comb begin
        if (ser_mode) begin
            nxt_state = latch_en ? ST_SER_HOLD : ST_SER_SHIFT;
        end else begin
            nxt_state = latch_en ? ST_PAR_OPEN : ST_PAR_HOLD;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_state <= ST_BOOT;
        end else begin
            cur_state <= nxt_state;
        end
    end

    // Transition actions.
    always_comb begin
        shift_en   = (nxt_state == ST_SER_SHIFT) && sclk_rise;
        load_par   = (nxt_state == ST_PAR_OPEN);
        load_shift = 1'b0;
        unique case (cur_state)
            ST_BOOT:      load_shift = 1'b0;
            ST_SER_SHIFT: load_shift = (nxt_state == ST_SER_HOLD);
            ST_SER_HOLD:  load_shift = 1'b0;
            ST_PAR_OPEN:  load_shift = 1'b0;
            ST_PAR_HOLD:  load_shift = (nxt_state == ST_SER_HOLD);
            default:      load_shift = 1'b0;
        endcase
    end

    assign state = cur_state;

    // R5: at most one source loads the output register in any clock.
    p_single_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_par, load_shift}));

    // R4: no shift is issued while latch enable is high.
    p_shift_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        latch_en |-> !shift_en);

endmodule

// File: rtl/atten_shift.sv
module atten_shift #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] shift_word
);

    logic [W-1:0] sreg;

    // Bits enter at bit 0 and move up, so the first bit sent ends at the MSB.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (shift_en) begin
            sreg <= {sreg[W-2:0], din};
        end
    end

    assign shift_word = sreg;

endmodule

// File: rtl/atten_hold.sv
module atten_hold #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_par,
    input  logic         load_shift,
    input  logic [W-1:0] par_word,
    input  logic [W-1:0] shift_word,
    output logic [W-1:0] code
);

    // Power-up value: every stage enabled, i.e. maximum attenuation.
    localparam logic [W-1:0] MAX_CODE = '1;

    logic [W-1:0] code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= MAX_CODE;
        end else if (load_par) begin
            code_q <= par_word;
        end else if (load_shift) begin
            code_q <= shift_word;
        end
    end

    assign code = code_q;

endmodule

// File: rtl/atten_weight_sum.sv
module atten_weight_sum #(
    parameter int W = 7
) (
    input  logic [W-1:0] sel,
    output logic [W-1:0] total
);

    // With binary weights the sum of all stages, 2^W - 1, still fits in W bits.
    logic [W-1:0] weight [W];

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_weight
            assign weight[gi] = sel[gi] ? W'(1 << gi) : '0;
        end
    endgenerate

    always_comb begin
        total = '0;
        for (int i = 0; i < W; i++) begin
            total = total + weight[i];
        end
    end

endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
    import step_atten_pkg::*;
#(
    parameter int W = STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_mode,
    input  logic         ser_clk,
    input  logic         ser_din,
    input  logic         latch_en,
    input  logic [W-1:0] par_word,
    output logic [W-1:0] stage_sel,
    output logic [W-1:0] atten_qdb
);

    localparam int TOP_BIT = W - 1;

    logic         shift_en;
    logic         load_shift;
    logic         load_par;
    ctrl_state_e  state;
    logic [W-1:0] shift_word;

    atten_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_mode   (ser_mode),
        .latch_en   (latch_en),
        .ser_clk    (ser_clk),
        .shift_en   (shift_en),
        .load_shift (load_shift),
        .load_par   (load_par),
        .state      (state)
    );

    atten_shift #(.W(W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (shift_en),
        .din        (ser_din),
        .shift_word (shift_word)
    );

    atten_hold #(.W(W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_par   (load_par),
        .load_shift (load_shift),
        .par_word   (par_word),
        .shift_word (shift_word),
        .code       (stage_sel)
    );

    atten_weight_sum #(.W(W)) u_sum (
        .sel   (stage_sel),
        .total (atten_qdb)
    );

    // R7, R9: with latch enable low the stage selects do not move.
    p_hold_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en |=> $stable(stage_sel));

    // R4, R2: the shift register is frozen with the latch high or in parallel mode.
    p_shift_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en || !ser_mode) |=> $stable(shift_word));

    // R5: a latch rise in serial mode delivers the shifted word.
    p_serial_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SER_SHIFT && ser_mode && latch_en) |=> (stage_sel == $past(shift_word)));

    // R6: direct parallel mode passes the bus one clock later.
    p_direct_par_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_mode && latch_en) |=> (stage_sel == $past(par_word)));

    // R8: the top stage alone contributes half of the full scale.
    p_top_weight_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stage_sel[TOP_BIT] |-> (atten_qdb >= W'(1 << TOP_BIT)));

endmodule

// File: tb/step_atten_ctrl_tb.sv
`timescale 1ns/1ps
module step_atten_ctrl_tb;

    localparam int W = 7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ser_mode = 1'b1;
    logic         ser_clk = 1'b0;
    logic         ser_din = 1'b0;
    logic         latch_en = 1'b0;
    logic [W-1:0] par_word = '0;
    logic [W-1:0] stage_sel;
    logic [W-1:0] atten_qdb;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    int prev;

    always #4 clk = ~clk;

    step_atten_ctrl #(.W(W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_mode  (ser_mode),
        .ser_clk   (ser_clk),
        .ser_din   (ser_din),
        .latch_en  (latch_en),
        .par_word  (par_word),
        .stage_sel (stage_sel),
        .atten_qdb (atten_qdb)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Checks the stage selects and the quarter-dB sum (R8 weights: bit i = 2^i).
    task automatic chk_out(input string req, input int exp);
        int sum;
        sum = 0;
        for (int i = 0; i < W; i++) begin
            if (exp[i]) sum += (1 << i);
        end
        chk(req, int'(stage_sel), exp);
        chk({req, "/R8"}, int'(atten_qdb), sum);
    endtask

    // Sends n bits, MSB first, using one shift-clock pulse per bit.
    task automatic send_bits(input int bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_din = bits[i];
            ser_clk = 1'b0;
            step();
            ser_clk = 1'b1;
            step();
            ser_clk = 1'b0;
        end
        step();
    endtask

    task automatic latch_pulse();
        latch_en = 1'b1;
        step();
    endtask

    initial begin
        #(8ns * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step();
        step();
        rst_n = 1'b1;
        step();
        // R1: power-up state is maximum attenuation.
        chk_out("R1 reset max", 127);
        // R1: the shift register was cleared, so a transfer yields 0.
        latch_pulse();
        chk_out("R1 shift cleared", 0);
        latch_en = 1'b0;
        step();
        prev = 0;

        // R3, R5, R8: every code over the serial path.
        for (int c = 0; c < 128; c++) begin
            send_bits(c, W);
            chk_out("R5 no change before latch", prev);
            latch_pulse();
            chk_out("R3 serial code", c);
            latch_en = 1'b0;
            step();
            prev = c;
        end

        // R4: shift-clock edges while the latch is high are ignored.
        latch_en = 1'b1;
        for (int k = 0; k < 5; k++) begin
            ser_din = 1'b0;
            ser_clk = 1'b1;
            step();
            ser_clk = 1'b0;
            step();
        end
        latch_en = 1'b0;
        step();
        latch_pulse();
        chk_out("R4 masked shift", 127);
        latch_en = 1'b0;
        step();

        // R10: an over-length stream keeps the last seven bits.
        send_bits(10'b1110010110, 10);
        latch_pulse();
        chk_out("R10 overrun", 7'b0010110);

        // R2: the parallel bus has no effect while in serial mode.
        for (int k = 0; k < 4; k++) begin
            par_word = W'(k * 29 + 3);
            step();
            chk_out("R2 bus ignored in serial", 22);
        end
        latch_en = 1'b0;
        step();

        // R2, R9: switching to parallel with the latch low, then shifting, changes nothing.
        ser_mode = 1'b0;
        par_word = 7'h55;
        step();
        chk_out("R9 mode change low", 22);
        send_bits(7'h2A, W);
        chk_out("R2 no shift in parallel", 22);
        latch_pulse();
        chk_out("R2 parallel load", 7'h55);
        latch_en = 1'b0;
        ser_mode = 1'b1;
        step();
        chk_out("R9 mode back low", 7'h55);
        latch_pulse();
        chk_out("R2 shift kept 22", 22);
        latch_en = 1'b0;
        step();

        // R6: direct parallel, all codes.
        ser_mode = 1'b0;
        latch_en = 1'b1;
        for (int c = 0; c < 128; c++) begin
            par_word = W'(c ^ 7'h2A);
            step();
            chk_out("R6 direct", c ^ 7'h2A);
        end

        // R7: latched parallel walk.
        latch_en = 1'b0;
        step();
        prev = 127 ^ 7'h2A;
        for (int k = 0; k < 16; k++) begin
            int v;
            v = (k * 37 + 5) & 127;
            par_word = W'(v);
            step();
            chk_out("R7 hold while low", prev);
            latch_pulse();
            chk_out("R7 pulse transfer", v);
            latch_en = 1'b0;
            par_word = W'(~v);
            step();
            chk_out("R7 held after fall", v);
            prev = v;
        end

        // R9: repeated mode toggles with the latch low.
        for (int k = 0; k < 4; k++) begin
            ser_mode = ~ser_mode;
            par_word = W'(k * 11);
            step();
            chk_out("R9 toggle", prev);
        end

        // R1: reset in the middle of a run.
        rst_n = 1'b0;
        step();
        chk_out("R1 mid-run reset", 127);
        rst_n = 1'b1;
        step();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule